// File: doc/BRIEF.md
# Management Data Slave with Interrupt Register

This block is the management-bus end of a transceiver: a serial slave clocked by the management clock (MDC) that owns a single bidirectional data line (MDIO). It hunts for a frame start, decodes read and write frames, checks the addressed device number against a strapped three-bit value or the broadcast value zero, and then reads or writes one 16-bit register of a small bank. The pad is outside the block. It sees the line on `mdio_i` and drives it through `mdio_o` with the enable `mdio_oe_o`.

The bank holds four plain storage words, one read-only identifier, a configuration word and an interrupt word. The interrupt word combines eight enable bits with eight sticky status bits. One-cycle event pulses from the rest of the chip set the status bits. Reading the interrupt word returns the status and then clears it. An enabled, pending condition drives `irq_o`, and one configuration bit sets the polarity of that output. Other logic synchronous to MDC raises the events.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones sampled on `mdio_i`, followed by a 0 and then a 1. A frame preceded by only 31 ones gets no response and writes nothing.
- R2: After the start bits, the next two bits select the operation: 10 is a read and 01 is a write. Frames carrying 00 or 11 are ignored.
- R3: The next five bits are the device number, MSB first. The block responds only when bits 4:3 are 00 and bits 2:0 equal `phy_strap_i`, or when all five bits are zero. Any other value gets no drive and no write.
- R4: Device number 0 is a broadcast that is served for both reads and writes.
- R5: A read works as follows. The five register-number bits follow, MSB first. In the first turnaround bit period the line stays released. In the second, the block drives 0. Sixteen data bits follow, MSB first, each launched on an MDC rising edge. After the last data bit the line is released again. `mdio_oe_o` is never high outside the data phase of a read.
- R6: On a write, the master sends the two turnaround bits, which the block ignores, and then 16 data bits MSB first.
  - Registers 0 to 3 store the written value and read it back.
  - Register 8 always reads 16'h4A17 and ignores writes.
  - Unmapped register numbers read 0 and ignore writes.
- R7: Register 12 is the interrupt word. Bits 15:8 are writable enables. Bits 7:0 are status bits and ignore writes. A high pulse on `event_i[k]` sets status bit k, and the bit stays set until cleared.
- R8: A read of register 12 returns its pre-clear value and then clears bits 7:0.
- R9: An event pulse that coincides with the clearing cycle of a register-12 read is kept in the status bits after the clear.
- R10: The interrupt is active while any bit of (bits 15:8 AND bits 7:0) of register 12 is set. Bit 3 of register 13 (configuration, fully read/write) selects the polarity: 0 means active low and 1 means active high.
- R11: After reset, all writable registers hold 0, `irq_o` is 1 and `mdio_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; all logic uses its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phy_strap_i | input | 3 | Strapped device number, 1 to 7 |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line |
| event_i | input | 8 | One-cycle event pulses, bit k sets status bit k |
| irq_o | output | 1 | Interrupt output, polarity from register 13 bit 3 |

## Verification
Two things can land on the same MDC edge: the clearing step of a register-12 read and a fresh event pulse on `event_i`. The bench aligns an event with the second turnaround bit of a read, which is the edge where the status is captured and cleared. It then checks three things. The returned word must exclude the new event, `irq_o` must reflect that event right after the read, and a second read must return exactly that event. Random frames with random device numbers, registers and event pulses are scored against a bench model of the register bank.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST1, S_HDR, S_RTA, S_RDAT, S_WTA, S_WDAT
  } frame_state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam int PHY_AW  = 5;
  localparam int REG_AW  = 5;
  localparam int STRAP_W = 3;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              rd_phase_o
);
  localparam int HDR_W = 2 + PHY_AW + REG_AW;
  localparam int CNT_W = $clog2(PRE_LEN + DATA_W + 1);
  localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DAT_END  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  frame_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] sh_q;
  logic [REG_AW-1:0] addr_q;
  logic              oe_q, out_q;

  logic [HDR_W-1:0]  hdr_full;
  logic [1:0]        op;
  logic [PHY_AW-1:0] phy;
  logic [REG_AW-1:0] regad;
  logic              phy_hit;

  assign hdr_full = {hdr_q[HDR_W-2:0], mdio_i};
  assign op       = hdr_full[HDR_W-1 -: 2];
  assign phy      = hdr_full[REG_AW +: PHY_AW];
  assign regad    = hdr_full[REG_AW-1:0];
  // upper bits must be zero; lower bits match strap or broadcast zero
  assign phy_hit  = (phy[PHY_AW-1:STRAP_W] == '0) &&
                    ((phy[STRAP_W-1:0] == strap_i) || (phy[STRAP_W-1:0] == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PRE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      case (state_q)
        S_PRE: begin
          if (mdio_i) begin
            if (cnt_q != PRE_CNT) cnt_q <= cnt_q + CNT_ONE;
          end else begin
            if (cnt_q == PRE_CNT) state_q <= S_ST1;
            cnt_q <= '0;
          end
        end
        S_ST1: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? S_HDR : S_PRE;
        end
        S_HDR: begin
          hdr_q <= hdr_full;
          cnt_q <= cnt_q + CNT_ONE;
          if (cnt_q == HDR_LAST) begin
            cnt_q  <= '0;
            addr_q <= regad;
            if (phy_hit && op == OP_READ)       state_q <= S_RTA;
            else if (phy_hit && op == OP_WRITE) state_q <= S_WTA;
            else                                state_q <= S_PRE;
          end
        end
        S_RTA: begin
          // first turnaround bit ends: capture word, drive the 0
          sh_q    <= rd_data_i;
          oe_q    <= 1'b1;
          out_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= S_RDAT;
        end
        S_RDAT: begin
          out_q <= sh_q[DATA_W-1];
          sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
          cnt_q <= cnt_q + CNT_ONE;
          if (cnt_q == DAT_END) begin
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_PRE;
          end
        end
        S_WTA: begin
          cnt_q <= cnt_q + CNT_ONE;
          if (cnt_q == CNT_ONE) begin
            cnt_q   <= '0;
            state_q <= S_WDAT;
          end
        end
        S_WDAT: begin
          sh_q  <= {sh_q[DATA_W-2:0], mdio_i};
          cnt_q <= cnt_q + CNT_ONE;
          if (cnt_q == DAT_LAST) begin
            cnt_q   <= '0;
            state_q <= S_PRE;
          end
        end
        default: begin
          state_q <= S_PRE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign rd_req_o   = (state_q == S_RTA);
  assign wr_en_o    = (state_q == S_WDAT) && (cnt_q == DAT_LAST);
  assign wr_data_o  = {sh_q[DATA_W-2:0], mdio_i};
  assign reg_addr_o = addr_q;
  assign mdio_o     = out_q;
  assign mdio_oe_o  = oe_q;
  assign rd_phase_o = (state_q == S_RDAT);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                NUM_STORE = 4,
  parameter logic [15:0]       ID_VALUE  = 16'h4A17,
  parameter logic [REG_AW-1:0] ID_ADDR   = 5'd8,
  parameter logic [REG_AW-1:0] IRQ_ADDR  = 5'd12,
  parameter logic [REG_AW-1:0] CFG_ADDR  = 5'd13,
  parameter int                POL_BIT   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] irq_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pol_o
);
  logic [DATA_W-1:0] store_q [NUM_STORE];
  logic [DATA_W-1:0] cfg_q;
  logic [NUM_STORE-1:0] store_hit;

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_hit
    assign store_hit[g] = (addr_i == REG_AW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_STORE; i++) store_q[i] <= '0;
      cfg_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_STORE; i++)
        if (store_hit[i]) store_q[i] <= wr_data_i;
      if (addr_i == CFG_ADDR) cfg_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (store_hit[i]) rd_data_o = store_q[i];
    if (addr_i == ID_ADDR)  rd_data_o = DATA_W'(ID_VALUE);
    if (addr_i == IRQ_ADDR) rd_data_o = irq_word_i;
    if (addr_i == CFG_ADDR) rd_data_o = cfg_q;
  end

  assign pol_o = cfg_q[POL_BIT];
endmodule

// File: rtl/mdio_irq_unit.sv
module mdio_irq_unit
  import mdio_mgmt_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [REG_AW-1:0] IRQ_ADDR = 5'd12,
  localparam int               EVT_W    = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  event_i,
  input  logic              wr_en_i,
  input  logic              rd_req_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [EVT_W-1:0]  en_wdata_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] irq_word_o,
  output logic [EVT_W-1:0]  status_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] en_q, st_q, pend;
  logic             rd_clr, active;

  assign rd_clr = rd_req_i && (addr_i == IRQ_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (wr_en_i && addr_i == IRQ_ADDR) en_q <= en_wdata_i;
      // a coinciding event survives the clear
      st_q <= (rd_clr ? '0 : st_q) | event_i;
    end
  end

  for (genvar k = 0; k < EVT_W; k++) begin : g_pend
    assign pend[k] = en_q[k] & st_q[k];
  end

  assign active     = |pend;
  assign irq_o      = pol_i ? active : ~active;
  assign irq_word_o = {en_q, st_q};
  assign status_o   = st_q;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int                PRE_LEN   = 32,
  parameter int                DATA_W    = 16,
  parameter int                NUM_STORE = 4,
  parameter logic [15:0]       ID_VALUE  = 16'h4A17,
  parameter logic [REG_AW-1:0] ID_ADDR   = 5'd8,
  parameter logic [REG_AW-1:0] IRQ_ADDR  = 5'd12,
  parameter logic [REG_AW-1:0] CFG_ADDR  = 5'd13,
  parameter int                POL_BIT   = 3
) (
  input  logic                  mdc_i,
  input  logic                  rst_ni,
  input  logic [2:0]            phy_strap_i,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  input  logic [DATA_W/2-1:0]   event_i,
  output logic                  irq_o
);
  localparam int EVT_W = DATA_W / 2;

  logic              rd_req, wr_en, rd_phase, pol;
  logic [REG_AW-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data, irq_word;
  logic [EVT_W-1:0]  irq_status;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_rx (
    .clk_i(mdc_i), .rst_ni(rst_ni), .mdio_i(mdio_i), .strap_i(phy_strap_i),
    .rd_data_i(rd_data), .rd_req_o(rd_req), .wr_en_o(wr_en),
    .reg_addr_o(reg_addr), .wr_data_o(wr_data), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .rd_phase_o(rd_phase)
  );

  mdio_reg_bank #(
    .DATA_W(DATA_W), .NUM_STORE(NUM_STORE), .ID_VALUE(ID_VALUE),
    .ID_ADDR(ID_ADDR), .IRQ_ADDR(IRQ_ADDR), .CFG_ADDR(CFG_ADDR), .POL_BIT(POL_BIT)
  ) u_bank (
    .clk_i(mdc_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(reg_addr),
    .wr_data_i(wr_data), .irq_word_i(irq_word), .rd_data_o(rd_data), .pol_o(pol)
  );

  mdio_irq_unit #(.DATA_W(DATA_W), .IRQ_ADDR(IRQ_ADDR)) u_irq (
    .clk_i(mdc_i), .rst_ni(rst_ni), .event_i(event_i), .wr_en_i(wr_en),
    .rd_req_i(rd_req), .addr_i(reg_addr), .en_wdata_i(wr_data[DATA_W-1 -: EVT_W]),
    .pol_i(pol), .irq_word_o(irq_word), .status_o(irq_status), .irq_o(irq_o)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int          DATA_W   = 16,
  parameter logic [4:0]  IRQ_ADDR = 5'd12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mdio_oe_i,
  input logic                mdio_o_i,
  input logic                rd_phase_i,
  input logic                rd_req_i,
  input logic                wr_en_i,
  input logic [4:0]          reg_addr_i,
  input logic [DATA_W/2-1:0] event_i,
  input logic [DATA_W/2-1:0] status_i
);
  logic rd_clr;
  assign rd_clr = rd_req_i && (reg_addr_i == IRQ_ADDR);

  p_drive_in_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_i |-> rd_phase_i);

  p_ta_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_i) |-> !mdio_o_i);

  p_one_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_i && wr_en_i));

  p_evt_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((status_i & $past(event_i)) == $past(event_i)));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr |=> ((status_i & $past(status_i)) == $past(status_i)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && event_i == '0) |=> (status_i == '0));

  p_keep_evt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr |=> (status_i == $past(event_i)));
endmodule

bind mdio_mgmt_slave mdio_mgmt_checker #(.DATA_W(DATA_W), .IRQ_ADDR(IRQ_ADDR)) u_chk (
  .clk_i(mdc_i), .rst_ni(rst_ni), .mdio_oe_i(mdio_oe_o), .mdio_o_i(mdio_o),
  .rd_phase_i(rd_phase), .rd_req_i(rd_req), .wr_en_i(wr_en),
  .reg_addr_i(reg_addr), .event_i(event_i), .status_i(irq_status)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  localparam logic [2:0]  STRAP = 3'd5;
  localparam logic [15:0] IDV   = 16'h4A17;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic mst_oe = 1'b0, mst_val = 1'b1;
  logic dut_o, dut_oe, irq, line;
  logic [7:0] evt = '0;

  always #4 mdc = ~mdc;

  assign line = dut_oe ? dut_o : (mst_oe ? mst_val : 1'b1);

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .mdc_i(mdc), .rst_ni(rst_n), .phy_strap_i(STRAP), .mdio_i(line),
    .mdio_o(dut_o), .mdio_oe_o(dut_oe), .event_i(evt), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [15:0] m_store [4];
  logic [15:0] m_cfg;
  logic [7:0]  m_en, m_st;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [4:0] r);
    case (r)
      5'd0, 5'd1, 5'd2, 5'd3: return m_store[r[1:0]];
      5'd8:  return IDV;
      5'd12: return {m_en, m_st};
      5'd13: return m_cfg;
      default: return 16'h0;
    endcase
  endfunction

  function automatic void m_write(input logic [4:0] r, input logic [15:0] d);
    case (r)
      5'd0, 5'd1, 5'd2, 5'd3: m_store[r[1:0]] = d;
      5'd12: m_en = d[15:8];
      5'd13: m_cfg = d;
      default: ;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic act;
    act = |(m_en & m_st);
    return m_cfg[3] ? act : !act;
  endfunction

  task automatic send(input logic b);
    @(negedge mdc);
    mst_oe = 1'b1;
    mst_val = b;
  endtask

  task automatic header(input int pre, input logic [1:0] op, input logic [4:0] phy, input logic [4:0] r);
    repeat (pre) send(1'b1);
    send(1'b0); send(1'b1);
    for (int i = 1; i >= 0; i--) send(op[i]);
    for (int i = 4; i >= 0; i--) send(phy[i]);
    for (int i = 4; i >= 0; i--) send(r[i]);
  endtask

  // read frame; ev is pulsed on the clearing edge (second turnaround bit)
  task automatic do_read(input logic [4:0] phy, input logic [4:0] r, input bit resp,
                         input logic [7:0] ev, input int pre, input string req,
                         output logic [15:0] data);
    bit ta1_rel, ta2_ok, all_oe, any_oe, rel;
    header(pre, 2'b10, phy, r);
    @(negedge mdc);
    mst_oe = 1'b0;
    ta1_rel = !dut_oe;
    any_oe = dut_oe;
    evt = ev;
    @(negedge mdc);
    evt = '0;
    ta2_ok = dut_oe && !dut_o;
    any_oe |= dut_oe;
    all_oe = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      data[i] = line;
      all_oe &= dut_oe;
      any_oe |= dut_oe;
    end
    @(negedge mdc);
    rel = !dut_oe;
    if (resp) begin
      chk(ta1_rel, {req, " R5 turnaround released"}, 16'(!ta1_rel), 16'h0);
      chk(ta2_ok, {req, " R5 turnaround zero"}, 16'(ta2_ok), 16'h1);
      chk(all_oe && rel, {req, " R5 data drive then release"}, 16'(all_oe && rel), 16'h1);
    end else begin
      chk(!any_oe, {req, " no drive expected"}, 16'(any_oe), 16'h0);
    end
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d,
                          input int pre, input logic [1:0] op);
    header(pre, op, phy, r);
    send(1'b1); send(1'b0);
    for (int i = 15; i >= 0; i--) send(d[i]);
    @(negedge mdc);
    mst_oe = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge mdc);
    evt = ev;
    @(negedge mdc);
    evt = '0;
    m_st |= ev;
  endtask

  task automatic model_read(input logic [4:0] r, input logic [7:0] ev, output logic [15:0] e);
    e = m_read(r);
    if (r == 5'd12) m_st = ev; else m_st |= ev;
  endtask

  logic [15:0] rd, ex;
  logic [4:0] rsel [8] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd8, 5'd12, 5'd13, 5'd5};

  initial begin
    for (int i = 0; i < 4; i++) m_store[i] = '0;
    m_cfg = '0; m_en = '0; m_st = '0;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    // R11 reset state
    chk(irq == 1'b1, "R11 irq idle high", 16'(irq), 16'h1);
    chk(dut_oe == 1'b0, "R11 line released", 16'(dut_oe), 16'h0);
    do_read(5'd5, 5'd0, 1, 8'h0, 32, "R11", rd);
    chk(rd == 16'h0, "R11 reg0 reset", rd, 16'h0);
    do_read(5'd5, 5'd12, 1, 8'h0, 32, "R11", rd);
    chk(rd == 16'h0, "R11 irq reg reset", rd, 16'h0);
    do_read(5'd5, 5'd13, 1, 8'h0, 32, "R11", rd);
    chk(rd == 16'h0, "R11 cfg reset", rd, 16'h0);

    // R6 storage, id, unmapped
    do_write(5'd5, 5'd1, 16'hA5C3, 32, 2'b01); m_write(5'd1, 16'hA5C3);
    do_read(5'd5, 5'd1, 1, 8'h0, 32, "R6", rd);
    chk(rd == 16'hA5C3, "R6 reg1 readback", rd, 16'hA5C3);
    do_read(5'd5, 5'd8, 1, 8'h0, 32, "R6", rd);
    chk(rd == IDV, "R6 id value", rd, IDV);
    do_write(5'd5, 5'd8, 16'h1234, 32, 2'b01);
    do_read(5'd5, 5'd8, 1, 8'h0, 32, "R6", rd);
    chk(rd == IDV, "R6 id ignores write", rd, IDV);
    do_write(5'd5, 5'd5, 16'hFFFF, 32, 2'b01);
    do_read(5'd5, 5'd5, 1, 8'h0, 32, "R6", rd);
    chk(rd == 16'h0, "R6 unmapped reads zero", rd, 16'h0);

    // R4 broadcast
    do_write(5'd0, 5'd3, 16'h5A0F, 32, 2'b01); m_write(5'd3, 16'h5A0F);
    do_read(5'd5, 5'd3, 1, 8'h0, 32, "R4", rd);
    chk(rd == 16'h5A0F, "R4 broadcast write", rd, 16'h5A0F);
    do_read(5'd0, 5'd1, 1, 8'h0, 32, "R4", rd);
    chk(rd == 16'hA5C3, "R4 broadcast read", rd, 16'hA5C3);

    // R3 address filter
    do_read(5'd3, 5'd1, 0, 8'h0, 32, "R3 wrong low bits", rd);
    do_read(5'd13, 5'd1, 0, 8'h0, 32, "R3 upper bit set", rd);
    do_write(5'd3, 5'd1, 16'h0000, 32, 2'b01);
    do_write(5'd21, 5'd1, 16'h0000, 32, 2'b01);
    do_read(5'd5, 5'd1, 1, 8'h0, 32, "R3", rd);
    chk(rd == 16'hA5C3, "R3 foreign writes ignored", rd, 16'hA5C3);

    // R2 bad opcodes
    do_write(5'd5, 5'd1, 16'h0F0F, 32, 2'b00);
    do_write(5'd5, 5'd1, 16'h0F0F, 32, 2'b11);
    do_read(5'd5, 5'd1, 1, 8'h0, 32, "R2", rd);
    chk(rd == 16'hA5C3, "R2 opcode 00/11 ignored", rd, 16'hA5C3);

    // R1 short preamble
    send(1'b0);
    do_read(5'd5, 5'd1, 0, 8'h0, 31, "R1 short read", rd);
    send(1'b0);
    do_write(5'd5, 5'd1, 16'h7777, 31, 2'b01);
    do_read(5'd5, 5'd1, 1, 8'h0, 32, "R1", rd);
    chk(rd == 16'hA5C3, "R1 short write ignored", rd, 16'hA5C3);

    // R7 enables and status
    do_write(5'd5, 5'd12, 16'h0FFF, 32, 2'b01); m_write(5'd12, 16'h0FFF);
    do_read(5'd5, 5'd12, 1, 8'h0, 32, "R7", rd);
    chk(rd == 16'h0F00, "R7 status ignores write", rd, 16'h0F00);
    m_st = '0;
    chk(irq == 1'b1, "R10 no pending idle high", 16'(irq), 16'h1);
    pulse(8'h01);
    chk(irq == 1'b0, "R10 active low assert", 16'(irq), 16'h0);
    model_read(5'd12, 8'h0, ex);
    do_read(5'd5, 5'd12, 1, 8'h0, 32, "R8", rd);
    chk(rd == 16'h0F01, "R8 read returns pre-clear", rd, 16'h0F01);
    chk(irq == 1'b1, "R8 cleared deasserts irq", 16'(irq), 16'h1);
    pulse(8'h10);
    chk(irq == 1'b1, "R7 disabled event no irq", 16'(irq), 16'h1);
    model_read(5'd12, 8'h0, ex);
    do_read(5'd5, 5'd12, 1, 8'h0, 32, "R7", rd);
    chk(rd == 16'h0F10, "R7 disabled event recorded", rd, 16'h0F10);

    // R9 event on the clearing edge
    pulse(8'h02);
    model_read(5'd12, 8'h04, ex);
    do_read(5'd5, 5'd12, 1, 8'h04, 32, "R9", rd);
    chk(rd == 16'h0F02, "R9 read excludes coinciding event", rd, 16'h0F02);
    chk(irq == 1'b0, "R9 coinciding event kept (irq)", 16'(irq), 16'h0);
    model_read(5'd12, 8'h0, ex);
    do_read(5'd5, 5'd12, 1, 8'h0, 32, "R9", rd);
    chk(rd == 16'h0F04, "R9 coinciding event kept (status)", rd, 16'h0F04);

    // R10 polarity
    do_write(5'd5, 5'd13, 16'h0008, 32, 2'b01); m_write(5'd13, 16'h0008);
    @(negedge mdc);
    chk(irq == 1'b0, "R10 active high idle low", 16'(irq), 16'h0);
    pulse(8'h08);
    chk(irq == 1'b1, "R10 active high assert", 16'(irq), 16'h1);

    // random traffic
    void'($urandom(32'd20240611));
    for (int it = 0; it < 60; it++) begin
      int kind;
      logic [4:0] r, phy;
      logic [15:0] d;
      bit ok_phy;
      kind = $urandom_range(0, 5);
      r = rsel[$urandom_range(0, 7)];
      d = 16'($urandom);
      case ($urandom_range(0, 3))
        0: phy = 5'd0;
        1: begin phy = 5'($urandom_range(1, 31)); if (phy == 5'd5) phy = 5'd2; end
        default: phy = 5'd5;
      endcase
      ok_phy = (phy == 5'd0) || (phy == 5'd5);
      if (kind <= 1) begin
        do_write(phy, r, d, 32, 2'b01);
        if (ok_phy) m_write(r, d);
      end else if (kind <= 3) begin
        logic [7:0] ev;
        ev = ($urandom_range(0, 1) == 1) ? 8'($urandom) : 8'h0;
        if (ok_phy) model_read(r, ev, ex);
        else m_st |= ev;
        do_read(phy, r, ok_phy, ev, 32, "R3 R6 random", rd);
        if (ok_phy) chk(rd == ex, "R6 R8 R9 random read", rd, ex);
      end else begin
        pulse(8'($urandom));
      end
      @(negedge mdc);
      chk(irq == exp_irq(), "R10 random irq", 16'(irq), 16'(exp_irq()));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule